// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests from a set of numbered priority levels and decides whether the core should take an interrupt. Each level keeps a 64-bit pending mask. Post and clear commands address the mask by a level number and a bit index. A status vector shows which levels have anything pending, and a check flag records that the pending set has grown since the last interrupt was dispatched.

Every cycle the block combines three things: the software request vector, the pending status of the external levels, and the core's current priority. From these it works out a winning priority and a summary vector. Software request bits are mapped to a small priority that counts from one at the lowest software level. External levels compete with their own level number, and they are scanned after the software levels, so they override them. An interrupt is taken only when all of these hold:

- the check flag is set;
- the core is not in privileged mode (the two PC low bits are zero);
- the winning priority is nonzero and strictly above the current priority.

A taken interrupt pulses a trap request. It also registers the priority and the summary one cycle after the inputs that caused it.

Top module: `ipc_ctrl`

## Requirements
- R1: A post with level and index in range sets that bit of the level's mask. One cycle later, `lvl_pend[level]` and `chk_pend` read 1.
- R2: A clear with level and index in range clears that bit. `lvl_pend[level]` drops only once every bit of that level's mask is zero. If post and clear are both asserted, the post wins.
- R3: A clear-all empties every level mask and `lvl_pend` in one cycle. It takes precedence over a post or clear in the same cycle.
- R4: A post or clear whose level is 32 or above, or whose index is 64 or above, changes no mask and no pending bit, and sets the sticky `cmd_err` output. Only reset clears `cmd_err`.
- R5: Each set bit i of `sw_req` in the software range 1..15 gives candidate priority i−1+1 = i−lowest+1 and sets bit i of the summary. `sw_req` bits outside 1..15 are ignored.
- R6: Each pending level i in the external range 16..31 gives candidate priority i and sets bit i of the summary. The highest pending external level wins over any software candidate. Pending levels 0..15 give no candidate.
- R7: An interrupt is taken only when the winning priority is nonzero and strictly greater than `cur_prio`, and `chk_pend` is set. The cycle after it is taken, `trap_req` is 1 for one cycle and `int_id` and `int_sum` show the priority and summary. Otherwise `int_id` and `int_sum` hold their values.
- R8: No interrupt is taken while `pc_lo` is nonzero.
- R9: Taking an interrupt clears `chk_pend` unless a valid post arrives in the same cycle. An interrupt that is not taken leaves `chk_pend` set, so a later drop of `cur_prio` or `pc_lo` lets it through.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Set the addressed pending bit |
| clr_vld | input | 1 | Clear the addressed pending bit |
| clr_all | input | 1 | Empty all pending masks |
| cmd_lvl | input | 6 | Level number for post or clear |
| cmd_idx | input | 7 | Bit index for post or clear |
| sw_req | input | 32 | Software request vector |
| cur_prio | input | 5 | Core's current priority |
| pc_lo | input | 2 | Low PC bits; nonzero means privileged mode |
| trap_req | output | 1 | One-cycle trap request |
| int_id | output | 5 | Priority of the last taken interrupt |
| int_sum | output | 32 | Summary of the last taken interrupt |
| lvl_pend | output | 32 | Per-level pending status |
| chk_pend | output | 1 | Check flag |
| cmd_err | output | 1 | Sticky out-of-range command flag |

## Verification
The checker holds the cycle-level rules on every cycle:
- a trap only above the current priority, only outside privileged mode and only while the check flag is set;
- the check flag and pending bit set by a post, and cleared by a take or a clear-all;
- the error flag staying set;
- the ID and summary holding between takes.

The scenarios show what a property cannot easily restate: the exact software remapping, external levels overriding software ones, a level's pending bit surviving the clear of one of two bits, and out-of-range commands leaving the masks untouched.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // Priority assigned to a software request bit: offset from the lowest software level, plus one.
  function automatic int unsigned sw_rank(input int unsigned bit_i, input int unsigned lo);
    return bit_i - lo + 1;
  endfunction

  // True when value lies strictly below limit.
  function automatic logic below(input int unsigned value, input int unsigned limit);
    return value < limit;
  endfunction
endpackage

// File: rtl/ipc_level_bank.sv
module ipc_level_bank #(
  parameter int NUM_LVL = 32,
  parameter int MASK_W  = 64,
  parameter int LVL_W   = 6,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_vld,
  input  logic               clr_vld,
  input  logic               clr_all,
  input  logic [LVL_W-1:0]   cmd_lvl,
  input  logic [IDX_W-1:0]   cmd_idx,
  output logic [NUM_LVL-1:0] lvl_pend,
  output logic               post_ok,
  output logic               clr_ok,
  output logic               cmd_bad
);
  import ipc_pkg::*;

  localparam int SEL_W = $clog2(MASK_W);

  logic              in_range;
  logic [MASK_W-1:0] bit_sel;

  assign in_range = below(int'(cmd_lvl), NUM_LVL) && below(int'(cmd_idx), MASK_W);
  assign post_ok  = post_vld && !clr_all && in_range;
  assign clr_ok   = clr_vld && !post_vld && !clr_all && in_range;
  assign cmd_bad  = (post_vld || clr_vld) && !clr_all && !in_range;
  assign bit_sel  = MASK_W'(1) << cmd_idx[SEL_W-1:0];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [MASK_W-1:0] mask_q;
    logic              hit;
    assign hit = (cmd_lvl == LVL_W'(l));

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        mask_q      <= '0;
        lvl_pend[l] <= 1'b0;
      end else if (post_ok && hit) begin
        mask_q      <= mask_q | bit_sel;
        lvl_pend[l] <= 1'b1;
      end else if (clr_ok && hit) begin
        mask_q      <= mask_q & ~bit_sel;
        lvl_pend[l] <= |(mask_q & ~bit_sel);
      end
    end
  end
endmodule

// File: rtl/ipc_prio_eval.sv
module ipc_prio_eval #(
  parameter int NUM_LVL = 32,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31,
  parameter int PRIO_W  = 5
) (
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [NUM_LVL-1:0] lvl_pend,
  output logic [PRIO_W-1:0]  eval_prio,
  output logic [NUM_LVL-1:0] eval_sum
);
  import ipc_pkg::*;

  always_comb begin
    eval_prio = '0;
    eval_sum  = '0;
    // Software levels first; later (higher) bits overwrite the priority.
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req[i]) begin
        eval_prio   = PRIO_W'(sw_rank(i, SW_LO));
        eval_sum[i] = 1'b1;
      end
    end
    // External levels last, so they override any software candidate.
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (lvl_pend[i]) begin
        eval_prio   = PRIO_W'(i);
        eval_sum[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl #(
  parameter int NUM_LVL = 32,
  parameter int MASK_W  = 64,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31,
  parameter int LVL_W   = $clog2(NUM_LVL) + 1,
  parameter int IDX_W   = $clog2(MASK_W) + 1,
  parameter int PRIO_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_vld,
  input  logic               clr_vld,
  input  logic               clr_all,
  input  logic [LVL_W-1:0]   cmd_lvl,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [PRIO_W-1:0]  cur_prio,
  input  logic [1:0]         pc_lo,
  output logic               trap_req,
  output logic [PRIO_W-1:0]  int_id,
  output logic [NUM_LVL-1:0] int_sum,
  output logic [NUM_LVL-1:0] lvl_pend,
  output logic               chk_pend,
  output logic               cmd_err
);
  logic               post_ok;
  logic               clr_ok;
  logic               cmd_bad;
  logic [PRIO_W-1:0]  eval_prio;
  logic [NUM_LVL-1:0] eval_sum;
  logic               priv_mode;
  logic               take_now;

  ipc_level_bank #(
    .NUM_LVL(NUM_LVL), .MASK_W(MASK_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .clr_vld(clr_vld),
    .clr_all(clr_all), .cmd_lvl(cmd_lvl), .cmd_idx(cmd_idx),
    .lvl_pend(lvl_pend), .post_ok(post_ok), .clr_ok(clr_ok), .cmd_bad(cmd_bad)
  );

  ipc_prio_eval #(
    .NUM_LVL(NUM_LVL), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .PRIO_W(PRIO_W)
  ) u_eval (
    .sw_req(sw_req), .lvl_pend(lvl_pend),
    .eval_prio(eval_prio), .eval_sum(eval_sum)
  );

  assign priv_mode = |pc_lo;
  assign take_now  = chk_pend && !priv_mode && (eval_prio != '0) && (eval_prio > cur_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      int_id   <= '0;
      int_sum  <= '0;
      chk_pend <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      trap_req <= take_now;
      if (take_now) begin
        int_id  <= eval_prio;
        int_sum <= eval_sum;
      end
      if (post_ok)       chk_pend <= 1'b1;
      else if (take_now) chk_pend <= 1'b0;
      if (cmd_bad) cmd_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ipc_ctrl_chk.sv
module ipc_ctrl_chk #(
  parameter int NUM_LVL = 32,
  parameter int LVL_W   = 6,
  parameter int PRIO_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_all,
  input logic [LVL_W-1:0]   cmd_lvl,
  input logic [PRIO_W-1:0]  cur_prio,
  input logic [1:0]         pc_lo,
  input logic               trap_req,
  input logic [PRIO_W-1:0]  int_id,
  input logic [NUM_LVL-1:0] int_sum,
  input logic [NUM_LVL-1:0] lvl_pend,
  input logic               chk_pend,
  input logic               cmd_err,
  input logic               post_ok,
  input logic               take_now
);
  AST_TRAP_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (int_id != '0 && int_id > $past(cur_prio))); // R7
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_now |=> ($stable(int_id) && $stable(int_sum) && !trap_req)); // R7
  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(pc_lo) == 2'b00)); // R8
  AST_TRAP_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(chk_pend)); // R9
  AST_TAKE_CLEARS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_now && !post_ok) |=> !chk_pend); // R9
  AST_POST_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok |=> (chk_pend && ((lvl_pend >> $past(cmd_lvl)) & NUM_LVL'(1)) != '0)); // R1
  AST_CLEAR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lvl_pend == '0)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err); // R4
endmodule

bind ipc_ctrl ipc_ctrl_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .cmd_lvl(cmd_lvl),
  .cur_prio(cur_prio), .pc_lo(pc_lo), .trap_req(trap_req), .int_id(int_id),
  .int_sum(int_sum), .lvl_pend(lvl_pend), .chk_pend(chk_pend), .cmd_err(cmd_err),
  .post_ok(post_ok), .take_now(take_now)
);

// File: tb/tb_ipc_ctrl.sv
module tb_ipc_ctrl;
  localparam int NL = 32;
  localparam int MW = 64;
  localparam int SWL = 1, SWH = 15, EXL = 16, EXH = 31;

  typedef struct packed {
    logic          trap;
    logic [4:0]    id;
    logic [NL-1:0] sum;
    logic [NL-1:0] pend;
    logic          chk;
    logic          err;
  } obs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic post_vld = 0, clr_vld = 0, clr_all = 0;
  logic [5:0] cmd_lvl = '0;
  logic [6:0] cmd_idx = '0;
  logic [NL-1:0] sw_req = '0;
  logic [4:0] cur_prio = '0;
  logic [1:0] pc_lo = '0;
  logic trap_req, chk_pend, cmd_err;
  logic [4:0] int_id;
  logic [NL-1:0] int_sum, lvl_pend;

  always #4 clk = ~clk; // 125 MHz

  ipc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .clr_vld(clr_vld), .clr_all(clr_all),
    .cmd_lvl(cmd_lvl), .cmd_idx(cmd_idx), .sw_req(sw_req), .cur_prio(cur_prio),
    .pc_lo(pc_lo), .trap_req(trap_req), .int_id(int_id), .int_sum(int_sum),
    .lvl_pend(lvl_pend), .chk_pend(chk_pend), .cmd_err(cmd_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  obs_t  exp_q[$];
  string tag_q[$];

  // Reference model state
  logic [MW-1:0] m_mask [NL];
  obs_t m;

  function automatic logic [NL-1:0] m_pend();
    logic [NL-1:0] p;
    for (int l = 0; l < NL; l++) p[l] = (m_mask[l] != '0);
    return p;
  endfunction

  // Highest pending external level, else highest software bit remapped.
  function automatic void m_eval(input logic [NL-1:0] sw, output int prio, output logic [NL-1:0] sum);
    logic [NL-1:0] p;
    p = m_pend();
    prio = 0;
    sum = '0;
    for (int i = EXH; i >= EXL; i--) if (p[i]) begin
      if (prio == 0) prio = i;
      sum[i] = 1'b1;
    end
    for (int i = SWH; i >= SWL; i--) if (sw[i]) begin
      if (prio == 0) prio = i - SWL + 1;
      sum[i] = 1'b1;
    end
  endfunction

  task automatic cyc(input logic p, input logic c, input logic ca, input int lvl, input int idx,
                     input logic [NL-1:0] sw, input int cur, input logic [1:0] pc, input string tag);
    int prio;
    logic [NL-1:0] sum;
    logic take, ok, bad;
    post_vld = p; clr_vld = c; clr_all = ca;
    cmd_lvl = 6'(lvl); cmd_idx = 7'(idx);
    sw_req = sw; cur_prio = 5'(cur); pc_lo = pc;
    m_eval(sw, prio, sum);
    take = m.chk && (pc == 2'b00) && (prio != 0) && (prio > cur);
    ok  = (p || c) && !ca && lvl < NL && idx < MW;
    bad = (p || c) && !ca && !(lvl < NL && idx < MW);
    @(posedge clk);
    #2;
    if (ca) for (int l = 0; l < NL; l++) m_mask[l] = '0;
    else if (ok && p) m_mask[lvl][idx] = 1'b1;
    else if (ok && c) m_mask[lvl][idx] = 1'b0;
    m.trap = take;
    if (take) begin m.id = 5'(prio); m.sum = sum; end
    if (ok && p) m.chk = 1'b1;
    else if (take) m.chk = 1'b0;
    if (bad) m.err = 1'b1;
    m.pend = m_pend();
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [NL-1:0] sw, input int cur, input logic [1:0] pc, input string tag);
    cyc(0, 0, 0, 0, 0, sw, cur, pc, tag);
  endtask

  task automatic cmp(input string f, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, f, a, e);
    end
  endtask

  // Monitor: pops expectations and compares at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp("trap_req", t, 64'(trap_req), 64'(e.trap));
      cmp("int_id",   t, 64'(int_id),   64'(e.id));
      cmp("int_sum",  t, 64'(int_sum),  64'(e.sum));
      cmp("lvl_pend", t, 64'(lvl_pend), 64'(e.pend));
      cmp("chk_pend", t, 64'(chk_pend), 64'(e.chk));
      cmp("cmd_err",  t, 64'(cmd_err),  64'(e.err));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m = '0;
    for (int l = 0; l < NL; l++) m_mask[l] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    idle('0, 0, 0, "R10 reset state");
    // R1 post external level, then R7 take and one-cycle pulse
    cyc(1, 0, 0, 20, 5, '0, 0, 0, "R1 post lvl20");
    idle('0, 0, 0, "R7 take lvl20");
    idle('0, 0, 0, "R9 no retake without post");
    // R7 not above current priority, then R9 held check lets it through later
    cyc(1, 0, 0, 18, 3, '0, 25, 0, "R1 post lvl18");
    idle('0, 25, 0, "R7 blocked by cur_prio");
    idle('0, 20, 0, "R7 equal priority not taken");
    idle('0, 17, 0, "R9 held check, R6 highest ext wins");
    idle('0, 17, 0, "R7 pulse ends");
    // R8 privileged mode
    cyc(1, 0, 0, 22, 9, '0, 0, 2'b01, "R8 post in priv");
    idle('0, 0, 2'b10, "R8 blocked");
    idle('0, 0, 2'b11, "R8 blocked");
    idle('0, 0, 2'b00, "R8 leave priv, take");
    idle('0, 0, 2'b00, "R8 settle");
    // R2 clear semantics
    cyc(0, 1, 0, 20, 5, '0, 31, 0, "R2 clear only bit of lvl20");
    cyc(1, 0, 0, 21, 0, '0, 31, 0, "R2 post lvl21 bit0");
    cyc(1, 0, 0, 21, 63, '0, 31, 0, "R2 post lvl21 bit63");
    cyc(0, 1, 0, 21, 0, '0, 31, 0, "R2 clear one of two");
    cyc(1, 1, 0, 19, 4, '0, 31, 0, "R2 post wins over clear");
    cyc(0, 1, 0, 21, 63, '0, 31, 0, "R2 clear last bit");
    // R4 out of range
    cyc(1, 0, 0, 40, 1, '0, 31, 0, "R4 level out of range");
    cyc(1, 0, 0, 25, 70, '0, 31, 0, "R4 index out of range");
    cyc(0, 1, 0, 19, 64, '0, 31, 0, "R4 clear index out of range");
    idle('0, 31, 0, "R4 error sticky");
    // R3 clear-all beats post
    cyc(1, 0, 1, 30, 2, '0, 31, 0, "R3 clear-all over post");
    idle('0, 31, 0, "R3 stays empty");
    // R5 software remap, bits outside range ignored
    cyc(1, 0, 0, 0, 0, 32'h0010_0089, 0, 0, "R5 post lvl0 with sw");
    idle(32'h0010_0089, 0, 0, "R5 sw bits 3,7 give prio 7");
    idle('0, 0, 0, "R5 settle");
    cyc(1, 0, 0, 5, 1, 32'h0000_8000, 14, 0, "R6 post sw-range level gives no candidate");
    idle(32'h0000_8000, 14, 0, "R5 top sw bit prio 15");
    // R6 external overrides software
    cyc(1, 0, 0, 16, 0, 32'h0000_8002, 0, 0, "R6 post lvl16");
    idle(32'h0000_8002, 0, 0, "R6 ext 16 beats sw 15");
    cyc(1, 0, 0, 31, 7, '0, 16, 0, "R6 post lvl31");
    idle('0, 16, 0, "R6 top level");
    idle('0, 0, 0, "R7 hold");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule